// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits. The RAM has one bidirectional data bus and a separate enable for each byte lane. A host request lasts one cycle and carries an address, write data, a two-bit byte mask and a direction. The controller expands it into a sequence of chip-select, write-enable, output-enable and byte-enable strobes. Every timing minimum is given in picoseconds and turned into a whole number of clock cycles. Each conversion rounds up, and each phase lasts at least one cycle.

A state machine in five states sets the order of events. `ST_IDLE` accepts a request and goes to `ST_WSETUP` for a write or `ST_RACCESS` for a read. `ST_WSETUP` holds the address, chip select and byte enables for the setup cycles, then goes to `ST_WPULSE`. `ST_WPULSE` holds write enable low for the write pulse. Its data drivers turn on only after the RAM's output turn-off time has passed. When the pulse count runs out it goes to `ST_RECOVER`. `ST_RACCESS` holds chip select and output enable low for the access window and captures the bus on its last cycle, then goes to `ST_RECOVER`. `ST_RECOVER` returns to `ST_IDLE` after the recovery cycles.

With the default 8 ns clock, the phases are: 1 setup cycle, a 3-cycle write pulse with data driven in its last 2 cycles, a 3-cycle read window, and 1 recovery cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset is released, `mem_cs_n`, `mem_we_n`, `mem_oe_n` and both `mem_be_n` bits are high, `mem_doe` is 0, and `busy` and `rvalid` are 0.
- R2: In a write, `mem_cs_n` and the selected byte enables are low for at least one cycle before `mem_we_n` falls, and `mem_oe_n` stays high for the whole time `mem_we_n` is low.
- R3: `mem_we_n` stays low for at least PULSE cycles. PULSE is the larger of ceil(15000 ps / clock) and the turn-off cycles plus the data-setup cycles, which is 3 at the default clock. `mem_cs_n` rises on the same edge as `mem_we_n`.
- R4: The controller never drives the bus while the RAM may drive it. `mem_doe` is 0 in the first ceil(8000 ps / clock) cycles after `mem_we_n` falls, and is 0 whenever `mem_oe_n` is low or `mem_we_n` is high.
- R5: Write data is driven, unchanged, for at least ceil(10000 ps / clock) cycles before `mem_we_n` rises, which is 2 cycles at the default clock.
- R6: Mask bit 0 selects `mem_be_n[0]` and data bits 7:0. Mask bit 1 selects `mem_be_n[1]` and bits 15:8. An unselected lane keeps its enable high and its `mem_doe` bit 0, and a write leaves that lane's stored byte unchanged.
- R7: A read holds the address, `mem_cs_n` and `mem_oe_n` low for 3 cycles at the default clock, which is enough to meet the 20 ns access time. The bus is captured on the last of these cycles. Bytes whose mask bit is 0 are returned as 0 in `rdata`.
- R8: `rvalid` is high for exactly one cycle. That cycle is the one after the read window closes, which is 3 cycles after the edge on which the request was accepted, and `rdata` is valid in it.
- R9: `busy` goes high on the edge that accepts a request. It stays high until recovery is done: 5 cycles for a write and 4 for a read at the default clock.
- R10: A request is accepted only while `busy` is low. A request raised while `busy` is high changes neither the strobes nor the memory. A request held high is accepted again on the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, sampled while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane select, bit 0 = low byte |
| busy | output | 1 | Access in progress |
| rvalid | output | 1 | One-cycle read-data strobe |
| rdata | output | 16 | Captured read data |
| mem_addr | output | 18 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | 2 | RAM byte enables, active low, bit 0 = low byte |
| mem_dout | output | 16 | Data toward the RAM |
| mem_din | input | 16 | Data from the RAM |
| mem_doe | output | 2 | Per-lane drive enable for mem_dout |

## Verification
The bench models the RAM. The model gives the byte `A5` on any lane whose enable is high, and `5A` until 20 ns have passed since a stable read access began. A controller that captured a cycle early, or failed to zero a masked byte, would therefore return visibly wrong bytes. The bench also watches which side drives the bus on each cycle. This catches data drivers that turn on in the first write-enable cycle, a write pulse one cycle short, and output enable low during a write. Requests raised during `busy`, and a request held high for many cycles, check that only idle cycles accept work: an ignored write would otherwise leave data at an address that the bench expects to read as zero.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_RACCESS,
        ST_RECOVER
    } ctrl_state_e;

    // Ceiling of t_ps / clk_ps, never below one cycle.
    function automatic int unsigned ps_to_cyc(int unsigned t_ps, int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Cycles left to reach a minimum cycle time, at least one.
    function automatic int unsigned rest_u(int unsigned need, int unsigned used);
        return (need > used) ? (need - used) : 1;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    always_comb begin
        if (restart)
            cnt_nxt = '0;
        else if (cnt_q == {CNT_W{1'b1}})
            cnt_nxt = cnt_q;
        else
            cnt_nxt = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANE_W-1:0] wdata_in,
    input  logic              drive_on,
    input  logic              lane_sel,
    input  logic              capture,
    input  logic [LANE_W-1:0] din,
    output logic              doe,
    output logic [LANE_W-1:0] dout,
    output logic [LANE_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            doe   <= 1'b0;
            dout  <= '0;
            rdata <= '0;
        end else begin
            if (load)
                dout <= wdata_in;
            doe <= drive_on && lane_sel;
            if (capture)
                rdata <= lane_sel ? din : '0;
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int LANES     = 2,
    parameter int LANE_W    = 8,
    parameter int CLK_PS    = 8000,
    parameter int T_AS_PS   = 0,
    parameter int T_WP_PS   = 15000,
    parameter int T_DW_PS   = 10000,
    parameter int T_WC_PS   = 20000,
    parameter int T_RC_PS   = 20000,
    parameter int T_AA_PS   = 20000,
    parameter int T_OE_PS   = 10000,
    parameter int T_WHZ_PS  = 8000,
    parameter int T_OHZ_PS  = 7000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    req_we,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    input  logic [LANES-1:0]        req_mask,
    output logic                    busy,
    output logic                    rvalid,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_cs_n,
    output logic                    mem_we_n,
    output logic                    mem_oe_n,
    output logic [LANES-1:0]        mem_be_n,
    output logic [LANES*LANE_W-1:0] mem_dout,
    input  logic [LANES*LANE_W-1:0] mem_din,
    output logic [LANES-1:0]        mem_doe
);

    localparam int unsigned SET_CYC   = ps_to_cyc(T_AS_PS,  CLK_PS);
    localparam int unsigned WP_CYC    = ps_to_cyc(T_WP_PS,  CLK_PS);
    localparam int unsigned DW_CYC    = ps_to_cyc(T_DW_PS,  CLK_PS);
    localparam int unsigned WHZ_CYC   = ps_to_cyc(T_WHZ_PS, CLK_PS);
    localparam int unsigned OHZ_CYC   = ps_to_cyc(T_OHZ_PS, CLK_PS);
    localparam int unsigned WC_CYC    = ps_to_cyc(T_WC_PS,  CLK_PS);
    localparam int unsigned RC_CYC    = ps_to_cyc(T_RC_PS,  CLK_PS);
    localparam int unsigned AA_CYC    = ps_to_cyc(T_AA_PS,  CLK_PS);
    localparam int unsigned OE_CYC    = ps_to_cyc(T_OE_PS,  CLK_PS);
    localparam int unsigned PULSE_CYC = max_u(WP_CYC, WHZ_CYC + DW_CYC);
    localparam int unsigned RD_CYC    = max_u(AA_CYC, max_u(OE_CYC, RC_CYC));
    localparam int unsigned REC_CYC   = max_u(OHZ_CYC,
                                         max_u(rest_u(WC_CYC, SET_CYC + PULSE_CYC),
                                               rest_u(RC_CYC, RD_CYC)));
    localparam int unsigned MAX_CYC   = max_u(max_u(SET_CYC, PULSE_CYC), max_u(RD_CYC, REC_CYC));
    localparam int          CNT_W     = $clog2(MAX_CYC + 2) + 1;

    localparam logic [CNT_W-1:0] SET_LAST   = CNT_W'(SET_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(REC_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_CNT   = CNT_W'(WHZ_CYC);

    ctrl_state_e        state, nstate;
    logic               restart;
    logic [CNT_W-1:0]   cnt_q, cnt_nxt;
    logic               accept, capture, drive_nxt, in_acc;
    logic [LANES-1:0]   mask_q, mask_nxt;

    // Next-state decision
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (req) nstate = req_we ? ST_WSETUP : ST_RACCESS;
            ST_WSETUP:  if (cnt_q == SET_LAST)   nstate = ST_WPULSE;
            ST_WPULSE:  if (cnt_q == PULSE_LAST) nstate = ST_RECOVER;
            ST_RACCESS: if (cnt_q == RD_LAST)    nstate = ST_RECOVER;
            ST_RECOVER: if (cnt_q == REC_LAST)   nstate = ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
    end

    assign restart   = (nstate != state);
    assign accept    = (state == ST_IDLE) && req;
    assign capture   = (state == ST_RACCESS) && (nstate == ST_RECOVER);
    assign mask_nxt  = accept ? req_mask : mask_q;
    assign in_acc    = (nstate == ST_WSETUP) || (nstate == ST_WPULSE) || (nstate == ST_RACCESS);
    assign drive_nxt = (nstate == ST_WPULSE) && (cnt_nxt >= TURN_CNT);

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    // Registered strobes, decoded from the coming state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_be_n <= '1;
            mem_addr <= '0;
            mask_q   <= '0;
            busy     <= 1'b0;
            rvalid   <= 1'b0;
        end else begin
            mem_cs_n <= !in_acc;
            mem_we_n <= (nstate != ST_WPULSE);
            mem_oe_n <= (nstate != ST_RACCESS);
            mem_be_n <= in_acc ? ~mask_nxt : '1;
            if (accept)
                mem_addr <= req_addr;
            mask_q   <= mask_nxt;
            busy     <= (nstate != ST_IDLE);
            rvalid   <= capture;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_io #(.LANE_W(LANE_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept && req_we),
            .wdata_in (req_wdata[g*LANE_W +: LANE_W]),
            .drive_on (drive_nxt),
            .lane_sel (mask_nxt[g]),
            .capture  (capture),
            .din      (mem_din[g*LANE_W +: LANE_W]),
            .doe      (mem_doe[g]),
            .dout     (mem_dout[g*LANE_W +: LANE_W]),
            .rdata    (rdata[g*LANE_W +: LANE_W])
        );

        // R6: a lane drives only while its byte enable is low
        p_lane_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            mem_doe[g] |-> !mem_be_n[g]);
    end

    // Pin-level run lengths observed for the checks below
    logic [CNT_W-1:0] we_low_len, drv_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_len <= '0;
            drv_len    <= '0;
        end else begin
            if (mem_we_n)
                we_low_len <= '0;
            else if (we_low_len != {CNT_W{1'b1}})
                we_low_len <= we_low_len + 1'b1;
            if (mem_doe == '0)
                drv_len <= '0;
            else if (drv_len != {CNT_W{1'b1}})
                drv_len <= drv_len + 1'b1;
        end
    end

    p_oe_high_in_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_setup_before_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_cs_n) == 1'b0));

    p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_len >= CNT_W'(PULSE_CYC)) && mem_cs_n);

    p_turnaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (mem_doe == '0));

    p_no_fight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_doe) |-> (mem_oe_n && !mem_we_n));

    p_data_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && (mask_q != '0)) |-> (drv_len >= CNT_W'(DW_CYC)));

    p_rvalid_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> busy);

endmodule

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

    localparam int W_BUSY = 5;   // R9 write
    localparam int R_BUSY = 4;   // R9 read
    localparam int RD_LAT = 3;   // R8

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        busy, rvalid;
    logic [15:0] rdata;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_be_n, mem_doe;
    logic [15:0] mem_dout;
    logic [15:0] mem_din = '0;

    always #4 clk = ~clk;

    sram_lane_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .busy(busy), .rvalid(rvalid),
        .rdata(rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dout(mem_dout),
        .mem_din(mem_din), .mem_doe(mem_doe)
    );

    int checks = 0, errors = 0, cycle = 0;
    bit finished = 0;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycle);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference model: request acceptance, busy length, read results
    logic [15:0] exp_mem [int];
    int          busy_left = 0, rv_cnt = 0;
    bit          exp_rv = 0;
    logic [15:0] exp_rdata = '0, pend_rdata = '0;

    function automatic logic [15:0] lane_mask(logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_left <= 0; rv_cnt <= 0; exp_rv <= 0;
        end else begin
            exp_rv <= 0;
            if (rv_cnt > 0) begin
                rv_cnt <= rv_cnt - 1;
                if (rv_cnt == 1) begin exp_rv <= 1; exp_rdata <= pend_rdata; end
            end
            if (busy_left == 0 && req) begin
                automatic logic [15:0] old = exp_mem.exists(int'(req_addr)) ? exp_mem[int'(req_addr)] : 16'h0;
                if (req_we) begin
                    busy_left <= W_BUSY;
                    exp_mem[int'(req_addr)] = (old & ~lane_mask(req_mask)) | (req_wdata & lane_mask(req_mask));
                end else begin
                    busy_left <= R_BUSY;
                    rv_cnt <= RD_LAT;
                    pend_rdata <= old & lane_mask(req_mask);
                end
            end else if (busy_left > 0) begin
                busy_left <= busy_left - 1;
            end
        end
    end

    // RAM model and pin checks, at the falling edge
    logic [15:0] ram [int];
    logic [7:0]  pend [2];
    bit   [1:0]  pend_v = '0;
    int          we_low = 0, drv_len = 0, age = 0;
    logic        prev_we = 1, prev_cs = 1, prev_rd = 0;
    logic [17:0] prev_addr = '0;

    always @(negedge clk) begin
        cycle++;
        if (cycle > 20000) begin
            chk(0, "watchdog", cycle, 0);
            summary();
        end
        if (rst_n) begin
            automatic logic ram_drv = !mem_cs_n && mem_we_n && !mem_oe_n;
            automatic logic [15:0] word;
            chk(busy === (busy_left > 0), "R9 R10 busy", busy, busy_left > 0);
            chk(rvalid === exp_rv, "R8 rvalid", rvalid, exp_rv);
            if (exp_rv) chk(rdata === exp_rdata, "R7 rdata", rdata, exp_rdata);
            if (ram_drv) chk(mem_doe == 2'b00, "R4 contention", mem_doe, 0);
            for (int i = 0; i < 2; i++)
                if (mem_doe[i]) chk(!mem_be_n[i], "R6 lane drive", mem_be_n, ~mem_doe);
            if (!mem_we_n) begin
                we_low++;
                chk(mem_oe_n, "R2 oe during write", mem_oe_n, 1);
                if (we_low == 1) begin
                    chk(mem_doe == 2'b00, "R4 turnaround", mem_doe, 0);
                    chk(prev_cs == 1'b0 && prev_we == 1'b1, "R2 setup", prev_cs, 0);
                end
                if (|mem_doe) drv_len++;
                for (int i = 0; i < 2; i++)
                    if (!mem_cs_n && !mem_be_n[i] && mem_doe[i]) begin
                        pend[i] = mem_dout[i*8 +: 8];
                        pend_v[i] = 1;
                    end
            end else if (prev_we == 1'b0) begin
                chk(we_low >= 3, "R3 pulse", we_low, 3);
                chk(mem_cs_n, "R3 cs end", mem_cs_n, 1);
                if (|pend_v) begin
                    chk(drv_len >= 2, "R5 data setup", drv_len, 2);
                    word = ram.exists(int'(prev_addr)) ? ram[int'(prev_addr)] : 16'h0;
                    for (int i = 0; i < 2; i++)
                        if (pend_v[i]) word[i*8 +: 8] = pend[i];
                    ram[int'(prev_addr)] = word;
                end
                pend_v = '0; we_low = 0; drv_len = 0;
            end
            if (ram_drv && prev_rd && mem_addr == prev_addr) age++;
            else if (ram_drv) age = 1;
            else age = 0;
            word = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0;
            for (int i = 0; i < 2; i++) begin
                if (!ram_drv || mem_be_n[i]) mem_din[i*8 +: 8] = 8'hA5;
                else if (age < 3)            mem_din[i*8 +: 8] = 8'h5A;
                else                         mem_din[i*8 +: 8] = word[i*8 +: 8];
            end
            prev_rd = ram_drv;
        end
        prev_we = mem_we_n; prev_cs = mem_cs_n; prev_addr = mem_addr;
    end

    task automatic issue(bit we, logic [17:0] a, logic [15:0] d, logic [1:0] m);
        @(negedge clk);
        while (busy_left != 0) @(negedge clk);
        req = 1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: strobes idle in reset
        chk(mem_cs_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11, "R1 strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_be_n}, 5'h1F);
        chk(mem_doe == 0 && !busy && !rvalid, "R1 outputs", {mem_doe, busy, rvalid}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !busy, "R1 after release", {mem_cs_n, mem_we_n, mem_oe_n, busy}, 4'hE);

        issue(1, 18'h00010, 16'h1234, 2'b11);
        issue(1, 18'h3FFFF, 16'hABCD, 2'b11);
        issue(1, 18'h00010, 16'hFF77, 2'b01);   // R6 low lane only
        issue(1, 18'h3FFFF, 16'h5599, 2'b10);   // R6 high lane only
        issue(1, 18'h00020, 16'hFFFF, 2'b00);   // R6 no lane
        issue(0, 18'h00010, 16'h0, 2'b11);      // R7 expect 1277
        issue(0, 18'h3FFFF, 16'h0, 2'b01);      // R7 expect 00CD
        issue(0, 18'h3FFFF, 16'h0, 2'b10);      // R7 expect 5500
        issue(0, 18'h00020, 16'h0, 2'b11);      // R6 expect 0
        issue(0, 18'h00010, 16'h0, 2'b00);      // R7 all masked

        // R10: request during busy is ignored
        issue(1, 18'h00030, 16'h4242, 2'b11);
        req = 1; req_we = 1; req_addr = 18'h00555; req_wdata = 16'hDEAD; req_mask = 2'b11;
        repeat (2) @(negedge clk);
        req = 0;
        issue(0, 18'h00555, 16'h0, 2'b11);      // R10 expect 0
        issue(0, 18'h00030, 16'h0, 2'b11);

        // R10: held request re-accepted on each idle cycle
        @(negedge clk);
        while (busy_left != 0) @(negedge clk);
        req = 1; req_we = 0; req_addr = 18'h3FFFF; req_mask = 2'b11;
        repeat (12) @(negedge clk);
        req = 0;

        repeat (12) @(negedge clk);
        summary();
    end

endmodule